// File: doc/BRIEF.md
# Cache Control and Invalidate Sequencer

This block is the register-facing control section of a memory cache. A plain 32-bit request bus (valid, write flag, 12-bit byte address, write data) reads a fixed identification word and a fixed size word. It also reads and writes a control word that drives the cache enable, write-allocate and critical-word-first-disable lines. Read data comes back registered, one clock after the request.

Any write to the trigger address starts a sweep that clears the valid flag of every cache line, one line per clock. While the sweep runs, the datapath is told to bypass the cache and the ready flag in the control word reads 0. The sweep can be started with the cache enabled and leaves the enable bit alone. A full sweep also runs by itself on leaving reset.

The per-line valid flags live inside the block. A fill port sets a line valid and a probe port reads one back, so that the effect of the sweep can be checked at the block's own pins.

Top module: `cache_ctl_seq`

## Requirements
- R1: Address 0x000 reads the identification word: release number in bits 5:0, part number in bits 9:6, identifier in bits 15:10, zeros above. Writes to it change nothing.
- R2: Address 0x004 reads the size word: cache size in bits 15:0, backing memory size in bits 31:16. Writes to it change nothing.
- R3: At address 0x100, bit 0 is the cache enable, bit 1 is write-allocate and bit 2 disables critical-word-first fill. These bits reset to 0, are written at the clock edge of the write request and drive `cache_en`, `wr_alloc` and `cwf_dis` from the following cycle.
- R4: Bit 16 of the word at 0x100 reads 1 when no sweep is running and 0 during a sweep. Writing it has no effect.
- R5: A write to 0x700 starts a sweep at that clock edge, whatever the data. Reads of 0x700 return 0.
- R6: During a sweep, `clr_valid` is 1 and `clr_idx` counts from 0 up to line count minus 1, advancing by one each clock. The line shown is cleared at the end of its cycle. `cache_ready` returns to 1 in the cycle after the last line is shown.
- R7: A trigger write during a sweep restarts it, with `clr_idx` 0 in the next cycle.
- R8: `bypass` is 1 whenever the enable bit is 0 or a sweep is running, and 0 otherwise.
- R9: Starting or running a sweep never changes the enable, write-allocate or critical-word-first-disable bits.
- R10: On leaving reset, a full sweep runs with `cache_ready` 0 until it completes.
- R11: Addresses other than 0x000, 0x004, 0x100 and 0x700 read 0, and writes to them change nothing.
- R12: `rd_data` takes the read value at the clock edge of the read request, computed from the state before that edge, and holds it until the next read.
- R13: `fill_en` sets the valid flag of line `fill_idx` at the clock edge. If the sweep clears that same line at that edge, the clear wins. `probe_valid` shows the flag of line `probe_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 12 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| fill_en | input | 1 | Mark a line valid |
| fill_idx | input | log2(LINES) | Line to mark valid |
| probe_idx | input | log2(LINES) | Line whose valid flag is shown |
| probe_valid | output | 1 | Valid flag of the probed line |
| clr_valid | output | 1 | Sweep is clearing a line this cycle |
| clr_idx | output | log2(LINES) | Line being cleared |
| bypass | output | 1 | Datapath must bypass the cache |
| cache_en | output | 1 | Cache enable |
| wr_alloc | output | 1 | Write-allocate select |
| cwf_dis | output | 1 | Critical-word-first fill disabled |
| cache_ready | output | 1 | No sweep running |

## Verification
Every result appears one clock edge after the stimulus that causes it. Read data, control outputs, the sweep index, ready and bypass all change at the edge that samples the request. A probed valid flag reflects the fill or clear made at the edge just before it. The bench drives inputs and samples outputs 1 ns after each rising edge. At the edge, its reference model advances from the same inputs the design saw, so every output is compared once per cycle against the state the model holds after that same edge. A sweep of 64 lines therefore reads ready again after exactly 64 edges, and the bench checks this in every cycle rather than at a guessed point.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_IDENT = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_SIZE  = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h100;
  localparam logic [ADDR_W-1:0] OFF_TRIG  = 12'h700;

  localparam int unsigned RDY_BIT = 16;

  typedef enum logic [2:0] {
    SEL_IDENT,
    SEL_SIZE,
    SEL_CTRL,
    SEL_TRIG,
    SEL_RSVD
  } reg_sel_e;

  typedef struct packed {
    logic cwf_dis;
    logic wr_alloc;
    logic en;
  } ctrl_t;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_IDENT: return SEL_IDENT;
      OFF_SIZE:  return SEL_SIZE;
      OFF_CTRL:  return SEL_CTRL;
      OFF_TRIG:  return SEL_TRIG;
      default:   return SEL_RSVD;
    endcase
  endfunction

  function automatic logic [31:0] ident_word(input logic [5:0] rel,
                                             input logic [3:0] part,
                                             input logic [5:0] ident);
    return {16'h0000, ident, part, rel};
  endfunction

  function automatic logic [31:0] size_word(input logic [15:0] cache_sz,
                                            input logic [15:0] mem_sz);
    return {mem_sz, cache_sz};
  endfunction

  function automatic logic [31:0] ctrl_word(input ctrl_t c, input logic rdy);
    logic [31:0] w;
    w = 32'h0;
    w[2:0] = c;
    w[RDY_BIT] = rdy;
    return w;
  endfunction

endpackage

// File: rtl/ccs_regfile.sv
module ccs_regfile
  import ccs_pkg::*;
#(
  parameter logic [5:0]  REL_NUM  = 6'd1,
  parameter logic [3:0]  PART_NUM = 4'd2,
  parameter logic [5:0]  IDENT    = 6'd3,
  parameter logic [15:0] CACHE_SZ = 16'd16,
  parameter logic [15:0] MEM_SZ   = 16'd1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              sweep_idle,
  output logic [31:0]       rd_data,
  output ctrl_t             ctrl,
  output logic              trig_wr,
  output logic              ctrl_wr
);

  reg_sel_e    sel;
  logic        rd_en;
  logic        wr_en;
  logic [31:0] rd_mux;
  logic        unused_wdata;
  ctrl_t       ctrl_q;
  logic [31:0] rd_q;

  assign sel          = decode_addr(req_addr);
  assign rd_en        = req_valid & ~req_write;
  assign wr_en        = req_valid & req_write;
  assign trig_wr      = wr_en && (sel == SEL_TRIG);
  assign ctrl_wr      = wr_en && (sel == SEL_CTRL);
  assign unused_wdata = ^req_wdata[31:3];

  always_comb begin
    case (sel)
      SEL_IDENT: rd_mux = ident_word(REL_NUM, PART_NUM, IDENT);
      SEL_SIZE:  rd_mux = size_word(CACHE_SZ, MEM_SZ);
      SEL_CTRL:  rd_mux = ctrl_word(ctrl_q, sweep_idle);
      default:   rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_t'(req_wdata[2:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 32'h0;
    end else if (rd_en) begin
      rd_q <= rd_mux;
    end
  end

  assign rd_data = rd_q;
  assign ctrl    = ctrl_q;

  // R5: trigger address reads back zero
  a_r5_trig_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (sel == SEL_TRIG) |=> rd_data == 32'h0);

  // R11: reserved space reads back zero
  a_r11_rsvd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (sel == SEL_RSVD) |=> rd_data == 32'h0);

  // R3: control bits move only on a control write
  a_r3_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl_q));

  // R12: read data holds between reads
  a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/ccs_sweeper.sv
module ccs_sweeper #(
  parameter int unsigned LINES = 64,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [IDX_W-1:0] probe_idx,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic             probe_valid
);

  // LINES is expected to be a power of two of at least 2.
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  logic [LINES-1:0] valid_q;
  logic             at_last;

  assign at_last = (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (restart) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (active_q) begin
      if (at_last) begin
        active_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      valid_q[fill_idx] <= 1'b1;
    end
    if (active_q) begin
      valid_q[idx_q] <= 1'b0;
    end
  end

  assign active      = active_q;
  assign idx         = idx_q;
  assign probe_valid = valid_q[probe_idx];

  // R6: index advances by one per clock inside a sweep
  a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !restart && !at_last |=> active_q && (idx_q == $past(idx_q) + 1'b1));

  // R6: sweep ends after the last line
  a_r6_done: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && at_last && !restart |=> !active_q);

  // R6: the line shown is cleared
  a_r6_line_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |=> !valid_q[$past(idx_q)]);

  // R7: a trigger restarts at line 0
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> active_q && (idx_q == '0));

  // R13: a fill not hit by a clear leaves the line valid
  a_r13_fill_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && !(active_q && (fill_idx == idx_q)) |=> valid_q[$past(fill_idx)]);

endmodule

// File: rtl/cache_ctl_seq.sv
module cache_ctl_seq
  import ccs_pkg::*;
#(
  parameter int unsigned LINES    = 64,
  parameter logic [5:0]  REL_NUM  = 6'd1,
  parameter logic [3:0]  PART_NUM = 4'd2,
  parameter logic [5:0]  IDENT    = 6'd3,
  parameter logic [15:0] CACHE_SZ = 16'd16,
  parameter logic [15:0] MEM_SZ   = 16'd1024,
  localparam int unsigned IDX_W   = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [11:0]      req_addr,
  input  logic [31:0]      req_wdata,
  output logic [31:0]      rd_data,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [IDX_W-1:0] probe_idx,
  output logic             probe_valid,
  output logic             clr_valid,
  output logic [IDX_W-1:0] clr_idx,
  output logic             bypass,
  output logic             cache_en,
  output logic             wr_alloc,
  output logic             cwf_dis,
  output logic             cache_ready
);

  ctrl_t            ctrl;
  logic             trig_wr;
  logic             ctrl_wr;
  logic             sweep_active;
  logic [IDX_W-1:0] sweep_idx;

  ccs_regfile #(
    .REL_NUM (REL_NUM),
    .PART_NUM(PART_NUM),
    .IDENT   (IDENT),
    .CACHE_SZ(CACHE_SZ),
    .MEM_SZ  (MEM_SZ)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .sweep_idle(!sweep_active),
    .rd_data   (rd_data),
    .ctrl      (ctrl),
    .trig_wr   (trig_wr),
    .ctrl_wr   (ctrl_wr)
  );

  ccs_sweeper #(
    .LINES(LINES)
  ) u_sweep (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (trig_wr),
    .fill_en    (fill_en),
    .fill_idx   (fill_idx),
    .probe_idx  (probe_idx),
    .active     (sweep_active),
    .idx        (sweep_idx),
    .probe_valid(probe_valid)
  );

  assign clr_valid   = sweep_active;
  assign clr_idx     = sweep_idx;
  assign cache_en    = ctrl.en;
  assign wr_alloc    = ctrl.wr_alloc;
  assign cwf_dis     = ctrl.cwf_dis;
  assign cache_ready = !sweep_active;
  assign bypass      = !ctrl.en || sweep_active;

  // R8: cache is used only when enabled and idle
  a_r8_no_bypass_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass |-> cache_en && cache_ready);

  // R9: a trigger leaves the control outputs unchanged
  a_r9_trig_keeps_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr |=> $stable(cache_en) && $stable(wr_alloc) && $stable(cwf_dis));

  // R4: ready low exactly while lines are being cleared
  a_r4_ready_vs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cache_ready |-> !clr_valid);

endmodule

// File: tb/cache_ctl_seq_bench.sv
module cache_ctl_seq_bench;

  localparam int N  = 64;
  localparam int IW = 6;
  localparam logic [5:0]  REL  = 6'h2A;
  localparam logic [3:0]  PART = 4'h9;
  localparam logic [5:0]  IDV  = 6'h15;
  localparam logic [15:0] CSZ  = 16'h0010;
  localparam logic [15:0] MSZ  = 16'h0200;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [11:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [31:0]   rd_data;
  logic          fill_en = 1'b0;
  logic [IW-1:0] fill_idx = '0;
  logic [IW-1:0] probe_idx = '0;
  logic          probe_valid, clr_valid, bypass, cache_en, wr_alloc, cwf_dis, cache_ready;
  logic [IW-1:0] clr_idx;

  always #5 clk = ~clk;

  cache_ctl_seq #(
    .LINES(N), .REL_NUM(REL), .PART_NUM(PART), .IDENT(IDV),
    .CACHE_SZ(CSZ), .MEM_SZ(MSZ)
  ) u_cache_ctl_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .fill_en(fill_en), .fill_idx(fill_idx), .probe_idx(probe_idx),
    .probe_valid(probe_valid), .clr_valid(clr_valid), .clr_idx(clr_idx),
    .bypass(bypass), .cache_en(cache_en), .wr_alloc(wr_alloc),
    .cwf_dis(cwf_dis), .cache_ready(cache_ready)
  );

  // reference model state
  bit          m_active;
  int          m_idx;
  bit          m_en, m_wa, m_cw;
  logic [31:0] m_rd;
  bit          m_valid[N];
  bit          m_known[N];

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  string cur_tag = "R10";
  string rd_tag = "R12";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    logic [31:0] w;
    w = 32'h0;
    if (a == 12'h000) w = (32'(IDV) << 10) | (32'(PART) << 6) | 32'(REL);
    else if (a == 12'h004) w = (32'(MSZ) << 16) | 32'(CSZ);
    else if (a == 12'h100) begin
      w = {29'h0, m_cw, m_wa, m_en};
      if (!m_active) w = w | 32'h0001_0000;
    end
    return w;
  endfunction

  task automatic model_update();
    bit pre_active;
    int pre_idx;
    if (!rst_n) begin
      m_active = 1; m_idx = 0; m_en = 0; m_wa = 0; m_cw = 0; m_rd = 32'h0;
      return;
    end
    pre_active = m_active;
    pre_idx    = m_idx;
    if (req_valid && !req_write) m_rd = exp_read(req_addr);
    if (fill_en) begin
      m_valid[fill_idx] = 1; m_known[fill_idx] = 1;
    end
    if (pre_active) begin
      m_valid[pre_idx] = 0; m_known[pre_idx] = 1;
      if (pre_idx == N - 1) m_active = 0;
      else m_idx = pre_idx + 1;
    end
    if (req_valid && req_write && req_addr == 12'h700) begin
      m_active = 1; m_idx = 0;
    end
    if (req_valid && req_write && req_addr == 12'h100) begin
      m_en = req_wdata[0]; m_wa = req_wdata[1]; m_cw = req_wdata[2];
    end
  endtask

  task automatic compare();
    chk({"R8 bypass/", cur_tag}, 32'(bypass), 32'(!m_en || m_active));
    chk({"R6 ready/", cur_tag}, 32'(cache_ready), 32'(!m_active));
    chk("R6 clr_valid", 32'(clr_valid), 32'(m_active));
    if (m_active) chk({"R6 clr_idx/", cur_tag}, 32'(clr_idx), 32'(m_idx));
    chk(m_active ? "R9 enable" : "R3 enable", 32'(cache_en), 32'(m_en));
    chk(m_active ? "R9 wr_alloc" : "R3 wr_alloc", 32'(wr_alloc), 32'(m_wa));
    chk(m_active ? "R9 cwf_dis" : "R3 cwf_dis", 32'(cwf_dis), 32'(m_cw));
    chk({"R12 rd_data/", rd_tag}, rd_data, m_rd);
    if (m_known[probe_idx]) chk("R13 probe", 32'(probe_valid), 32'(m_valid[probe_idx]));
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    #1;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    step();
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    req_valid = 1; req_write = 0; req_addr = a; rd_tag = tag;
    step();
    req_valid = 0;
  endtask

  task automatic fill(input int i);
    fill_en = 1; fill_idx = IW'(i);
    step();
    fill_en = 0;
  endtask

  task automatic probe(input int i);
    probe_idx = IW'(i);
    step();
  endtask

  initial begin
    // R10: reset state and the automatic sweep
    idle(3);
    rst_n = 1;
    idle(N + 4);

    cur_tag = "R1";
    rd(12'h000, "R1");
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, "R1");

    cur_tag = "R2";
    rd(12'h004, "R2");
    wr(12'h004, 32'h0);
    rd(12'h004, "R2");

    cur_tag = "R11";
    rd(12'h008, "R11");
    rd(12'h200, "R11");
    rd(12'h6FC, "R11");
    wr(12'h104, 32'h7);
    wr(12'h0FC, 32'h7);
    rd(12'h100, "R11");

    cur_tag = "R3";
    wr(12'h100, 32'h0001_0005);
    rd(12'h100, "R4");
    wr(12'h100, 32'h0000_0007);
    rd(12'h100, "R3");
    wr(12'h100, 32'hFFFF_FFF3);
    rd(12'h100, "R3");
    wr(12'h100, 32'h1);

    cur_tag = "R13";
    fill(5); fill(10); fill(N - 1); fill(40);
    probe(5); probe(10); probe(N - 1); probe(40); probe(7);

    cur_tag = "R5";
    wr(12'h700, 32'h0);
    rd(12'h700, "R5");
    rd(12'h100, "R5");
    idle(18);

    cur_tag = "R7";
    wr(12'h700, 32'hDEAD_BEEF);
    idle(4);
    fill_en = 1; fill_idx = IW'(m_idx);
    step();
    fill_en = 0;
    fill(50);
    idle(N + 4);
    probe(5); probe(10); probe(N - 1); probe(40); probe(50);

    cur_tag = "R8";
    wr(12'h100, 32'h0);
    idle(2);
    wr(12'h700, 32'h1);
    wr(12'h100, 32'h3);
    idle(N + 3);
    rd(12'h100, "R4");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule